// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of a parallel port running the extended-capability protocol in the reverse direction, where the peripheral sends bytes to the host. First it negotiates the reverse direction. The host pulls its reverse-request line low and waits until the peripheral confirms on its acknowledge-reverse line. After that it paces the peripheral with a host-ready line and captures one byte per four-phase interlock with the peripheral's strobe.

A tag line that is sampled with each byte marks the byte as data or as a command. A command with its top bit clear is a run count N. The data byte that follows is then written N+1 times into a byte FIFO. A command with its top bit set is a channel address, which the block records and does not queue. The CPU empties the FIFO with a read strobe, or a DMA engine empties it through a request/acknowledge pair with a terminal-count input.

All pins are active-low where their names end in `N`, and are taken as synchronous to `clk`.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `initN`=1, `autofdN`=1, `dmaReq`=0 and `fifoLevel`=0.
- R2: With `revEnable` high, `initN` is 0 from the next cycle. `autofdN` stays 1 until `perrN` is sampled 0. After that, `autofdN` goes 0 in the next cycle if the FIFO can accept a byte.
- R3: `faultN` low only raises `revHint`, and only while `initN` is 1. It never changes `initN` or the transfer direction.
- R4: A falling edge of `ackN` that is sampled while `autofdN` is 0 captures `pdIn` and `busyIn`. `autofdN` is then 1 from the next cycle and stays 1 for as long as `ackN` is sampled 0.
- R5: A byte captured with `busyIn`=1 is data and is written once to the FIFO. Bytes leave in arrival order: `rdData` shows the oldest byte, and `rdEn` pops it.
- R6: A byte captured with `busyIn`=0 and bit 7 = 0 sets a run count N from bits 6:0. The next data byte is written N+1 times (1 to 128), and the count is then used up.
- R7: A byte captured with `busyIn`=0 and bit 7 = 1 loads bits 6:0 into `chanAddr` and leaves the FIFO unchanged.
- R8: `autofdN` is 1 while the FIFO holds DEPTH (16) bytes or while a run is still being written. A run pauses when the FIFO is full and resumes as space frees.
- R9: `dmaReq` = `dmaEn` and FIFO non-empty and no terminal count seen. A `dmaAckN`=0 pulse with `tc`=1 ends requests until `dmaEn` goes low. Each `dmaAckN`=0 cycle pops one byte.
- R10: When a run write and a pop fall in the same cycle, both take effect: the level is unchanged and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| revEnable | input | 1 | Host software asks for reverse direction |
| perrN | input | 1 | Peripheral confirms reverse request when low |
| faultN | input | 1 | Peripheral's reverse-transfer hint, active low |
| ackN | input | 1 | Peripheral byte strobe |
| busyIn | input | 1 | Tag: 1 = data, 0 = command |
| pdIn | input | 8 | Parallel data from the peripheral |
| initN | output | 1 | Reverse request, low in reverse mode |
| autofdN | output | 1 | Host ready for a byte when low |
| revHint | output | 1 | Hint that the peripheral wants to send |
| rdEn | input | 1 | CPU pop strobe |
| rdData | output | 8 | Oldest FIFO byte |
| fifoLevel | output | 5 | Bytes held in the FIFO |
| chanAddr | output | 7 | Last channel address received |
| dmaEn | input | 1 | DMA service enable |
| dmaAckN | input | 1 | DMA acknowledge, pops one byte when low |
| tc | input | 1 | Terminal count, qualified by `dmaAckN` |
| dmaReq | output | 1 | DMA request |

## Verification
Run expansion writes and FIFO pops can land on the same clock edge. The bench provokes this by sending a 128-copy run while a reader pops every cycle in which the FIFO is non-empty. It judges the result by the popped count, the peak level and the byte sequence against a behavioural queue. A DMA acknowledge with terminal count is also issued while bytes remain queued. This checks that the request drops even though the FIFO is not empty.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_NEG   = 2'd1,
    PH_READY = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  typedef struct packed {
    logic dataLoad;
    logic runLoad;
    logic addrLoad;
  } ctrl_strobe_t;
endpackage

// File: rtl/ecp_rev_ctrl.sv
module ecp_rev_ctrl
  import ecp_rev_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         revEnable,
  input  logic         perrN,
  input  logic         faultN,
  input  logic         ackN,
  input  logic         busyIn,
  input  logic         cmdTop,
  input  logic         canAccept,
  output logic         initN,
  output logic         autofdN,
  output logic         revHint,
  output ctrl_strobe_t strobe
);
  phase_t phase, phaseNext;
  logic ackPrev;
  logic ackFall;
  logic request;
  logic take;

  assign ackFall = ackPrev & ~ackN;
  assign request = (phase == PH_READY) & canAccept;
  assign take    = request & ackFall;

  always_comb begin
    phaseNext = phase;
    if (!revEnable) begin
      phaseNext = PH_OFF;
    end else begin
      case (phase)
        PH_OFF:   phaseNext = PH_NEG;
        PH_NEG:   if (!perrN) phaseNext = PH_READY;
        PH_READY: if (take) phaseNext = PH_HOLD;
        PH_HOLD:  if (ackN) phaseNext = PH_READY;
        default:  phaseNext = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_OFF;
      ackPrev <= 1'b1;
    end else begin
      phase   <= phaseNext;
      ackPrev <= ackN;
    end
  end

  assign initN   = (phase == PH_OFF);
  assign autofdN = ~request;
  assign revHint = ~faultN & (phase == PH_OFF);

  assign strobe.dataLoad = take & busyIn;
  assign strobe.runLoad  = take & ~busyIn & ~cmdTop;
  assign strobe.addrLoad = take & ~busyIn & cmdTop;
endmodule

// File: rtl/ecp_rev_dp.sv
module ecp_rev_dp
  import ecp_rev_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int RUN_W  = DATA_W - 1,
  localparam int REP_W  = RUN_W + 1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [DATA_W-1:0] pdIn,
  input  logic              rdEn,
  input  logic              dmaEn,
  input  logic              dmaAckN,
  input  logic              tc,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic [RUN_W-1:0]  chanAddr,
  output logic              dmaReq,
  output logic              canAccept
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [RUN_W-1:0]  runLen;
  logic              runPending;
  logic [REP_W-1:0]  repLeft;
  logic [DATA_W-1:0] repByte;
  logic              tcSeen;
  logic              full, empty, push, pop;

  assign full      = (fifoLevel == LVL_W'(DEPTH));
  assign empty     = (fifoLevel == '0);
  assign push      = (repLeft != '0) & ~full;
  assign pop       = (rdEn | ~dmaAckN) & ~empty;
  assign canAccept = ~full & (repLeft == '0);
  assign rdData    = mem[rdPtr];
  assign dmaReq    = dmaEn & ~empty & ~tcSeen;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen     <= '0;
      runPending <= 1'b0;
      repLeft    <= '0;
      repByte    <= '0;
      chanAddr   <= '0;
    end else begin
      if (strobe.runLoad) begin
        runLen     <= pdIn[RUN_W-1:0];
        runPending <= 1'b1;
      end
      if (strobe.addrLoad) chanAddr <= pdIn[RUN_W-1:0];
      if (strobe.dataLoad) begin
        repByte    <= pdIn;
        repLeft    <= runPending ? REP_W'(runLen) + REP_W'(1) : REP_W'(1);
        runPending <= 1'b0;
      end else if (push) begin
        repLeft <= repLeft - REP_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= repByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   fifoLevel <= fifoLevel + LVL_W'(1);
        2'b01:   fifoLevel <= fifoLevel - LVL_W'(1);
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tcSeen <= 1'b0;
    else if (!dmaEn)           tcSeen <= 1'b0;
    else if (!dmaAckN && tc)   tcSeen <= 1'b1;
  end
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int RUN_W = DATA_W - 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              revEnable,
  input  logic              perrN,
  input  logic              faultN,
  input  logic              ackN,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] pdIn,
  output logic              initN,
  output logic              autofdN,
  output logic              revHint,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic [RUN_W-1:0]  chanAddr,
  input  logic              dmaEn,
  input  logic              dmaAckN,
  input  logic              tc,
  output logic              dmaReq
);
  ctrl_strobe_t strobe;
  logic canAccept;

  ecp_rev_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .revEnable(revEnable), .perrN(perrN),
    .faultN(faultN), .ackN(ackN), .busyIn(busyIn), .cmdTop(pdIn[DATA_W-1]),
    .canAccept(canAccept), .initN(initN), .autofdN(autofdN),
    .revHint(revHint), .strobe(strobe)
  );

  ecp_rev_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pdIn(pdIn), .rdEn(rdEn),
    .dmaEn(dmaEn), .dmaAckN(dmaAckN), .tc(tc), .rdData(rdData),
    .fifoLevel(fifoLevel), .chanAddr(chanAddr), .dmaReq(dmaReq),
    .canAccept(canAccept)
  );
endmodule

// File: rtl/ecp_rev_chk.sv
module ecp_rev_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             initN,
  input logic             autofdN,
  input logic             ackN,
  input logic             dmaEn,
  input logic             dmaAckN,
  input logic             tc,
  input logic             dmaReq,
  input logic [LVL_W-1:0] fifoLevel
);
  // R2
  no_req_before_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    initN |-> autofdN);

  // R4
  ack_interlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!autofdN && $fell(ackN)) |=> autofdN);

  // R8
  no_req_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LVL_W'(DEPTH)) |-> autofdN);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  // R9
  dma_idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == '0) |-> !dmaReq);

  // R9
  dma_tc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEn && !dmaAckN && tc) |=> !dmaReq);

  // R10
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == $past(fifoLevel)) || (fifoLevel == $past(fifoLevel) + LVL_W'(1))
    || (fifoLevel + LVL_W'(1) == $past(fifoLevel)));
endmodule

bind ecp_rev_rx ecp_rev_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .initN(initN), .autofdN(autofdN), .ackN(ackN),
  .dmaEn(dmaEn), .dmaAckN(dmaAckN), .tc(tc), .dmaReq(dmaReq),
  .fifoLevel(fifoLevel)
);

// File: tb/sim_ecp_rev_rx.sv
`timescale 1ns/1ps
module sim_ecp_rev_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic revEnable = 1'b0, perrN = 1'b1, faultN = 1'b1, ackN = 1'b1, busyIn = 1'b1;
  logic [7:0] pdIn = 8'h00;
  logic rdEn = 1'b0, dmaEn = 1'b0, dmaAckN = 1'b1, tc = 1'b0;
  logic initN, autofdN, revHint, dmaReq;
  logic [7:0] rdData;
  logic [4:0] fifoLevel;
  logic [6:0] chanAddr;

  always #5 clk = ~clk;

  ecp_rev_rx u0 (
    .clk(clk), .rstN(rstN), .revEnable(revEnable), .perrN(perrN), .faultN(faultN),
    .ackN(ackN), .busyIn(busyIn), .pdIn(pdIn), .initN(initN), .autofdN(autofdN),
    .revHint(revHint), .rdEn(rdEn), .rdData(rdData), .fifoLevel(fifoLevel),
    .chanAddr(chanAddr), .dmaEn(dmaEn), .dmaAckN(dmaAckN), .tc(tc), .dmaReq(dmaReq)
  );

  int checks = 0, fails = 0;
  logic [7:0] expQ[$];
  int pendRun = -1;
  logic [6:0] expAddr = '0;
  logic tcM = 1'b0;
  bit autoRead = 1'b0;
  int popCount = 0;
  int maxLevel = 0;
  bit sendsDone;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the behavioural queue
  always @(negedge clk) begin
    if (rstN) begin
      if (fifoLevel != 0)
        check(expQ.size() > 0 && rdData == expQ[0], "R5 head byte", rdData,
              expQ.size() > 0 ? expQ[0] : -1);
      check(dmaReq == (dmaEn && fifoLevel != 0 && !tcM), "R9 dmaReq", dmaReq,
            dmaEn && fifoLevel != 0 && !tcM);
      if (int'(fifoLevel) > maxLevel) maxLevel = fifoLevel;
      if ((rdEn || !dmaAckN) && fifoLevel != 0) begin
        void'(expQ.pop_front());
        popCount++;
      end
      if (!dmaEn) tcM = 1'b0;
      else if (!dmaAckN && tc) tcM = 1'b1;
    end
  end

  initial forever begin
    @(posedge clk);
    #1;
    rdEn = autoRead && fifoLevel != 0;
  end

  task automatic sendByte(input bit isData, input logic [7:0] v);
    @(negedge clk);
    while (autofdN) @(negedge clk);
    pdIn = v;
    busyIn = isData;
    if (isData) begin
      for (int k = 0; k < ((pendRun >= 0) ? pendRun + 1 : 1); k++) expQ.push_back(v);
      pendRun = -1;
    end else if (v[7]) expAddr = v[6:0];
    else pendRun = v[6:0];
    @(negedge clk);
    ackN = 1'b0;
    @(negedge clk);
    check(autofdN == 1'b1, "R4 autofd high after ack fall", autofdN, 1);
    @(negedge clk);
    check(autofdN == 1'b1, "R4 autofd held while ack low", autofdN, 1);
    ackN = 1'b1;
  endtask

  task automatic drain();
    autoRead = 1'b1;
    @(negedge clk);
    while (expQ.size() != 0 || fifoLevel != 0) @(negedge clk);
    autoRead = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic dmaPulse(input bit withTc);
    @(posedge clk); #1;
    dmaAckN = 1'b0; tc = withTc;
    @(posedge clk); #1;
    dmaAckN = 1'b1; tc = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1
    check(initN == 1 && autofdN == 1, "R1 reset lines", {initN, autofdN}, 3);
    check(dmaReq == 0 && fifoLevel == 0, "R1 reset fifo/dma", fifoLevel, 0);

    faultN = 1'b0;
    @(negedge clk);
    check(revHint == 1'b1, "R3 hint raised", revHint, 1);
    repeat (3) @(negedge clk);
    check(initN == 1'b1, "R3 fault does not reverse", initN, 1);
    faultN = 1'b1;

    revEnable = 1'b1;
    @(negedge clk);
    check(initN == 1'b0, "R2 init low", initN, 0);
    repeat (3) @(negedge clk);
    check(autofdN == 1'b1, "R2 no request before perr", autofdN, 1);
    perrN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(autofdN == 1'b0, "R2 request after perr", autofdN, 0);
    faultN = 1'b0;
    @(negedge clk);
    check(revHint == 1'b0 && initN == 1'b0, "R3 hint ignored in reverse", revHint, 0);
    faultN = 1'b1;

    // R5 plain data
    sendByte(1, 8'h11); sendByte(1, 8'h22); sendByte(1, 8'h33);
    repeat (3) @(negedge clk);
    check(fifoLevel == 3, "R5 three data bytes", fifoLevel, 3);
    drain();

    // R6 runs
    sendByte(0, 8'h05); sendByte(1, 8'hA5);
    repeat (10) @(negedge clk);
    check(fifoLevel == 6, "R6 run of six", fifoLevel, 6);
    sendByte(0, 8'h00); sendByte(1, 8'h42);
    repeat (3) @(negedge clk);
    check(fifoLevel == 7, "R6 zero count gives one copy", fifoLevel, 7);
    sendByte(1, 8'h43);
    repeat (3) @(negedge clk);
    check(fifoLevel == 8, "R6 count consumed", fifoLevel, 8);

    // R7 channel address
    sendByte(0, 8'h85);
    repeat (3) @(negedge clk);
    check(chanAddr == 7'h05, "R7 channel address", chanAddr, 5);
    check(fifoLevel == 8, "R7 fifo untouched", fifoLevel, 8);
    drain();

    // R8 fill and pause
    sendsDone = 1'b0;
    fork
      begin
        sendByte(0, 8'h14); sendByte(1, 8'h3C); sendByte(1, 8'h77);
        sendsDone = 1'b1;
      end
    join_none
    repeat (60) @(negedge clk);
    check(fifoLevel == 16, "R8 fifo full", fifoLevel, 16);
    check(autofdN == 1'b1, "R8 no request while full", autofdN, 1);
    autoRead = 1'b1;
    @(negedge clk);
    while (!sendsDone) @(negedge clk);
    drain();
    check(expQ.size() == 0, "R8 run resumed and completed", expQ.size(), 0);

    // R10 push and pop together
    autoRead = 1'b1;
    popCount = 0;
    maxLevel = 0;
    sendByte(0, 8'h7F); sendByte(1, 8'h5A);
    drain();
    check(popCount == 128, "R10 max run popped", popCount, 128);
    check(maxLevel <= 2, "R10 level stays low", maxLevel, 2);

    // R9 DMA
    for (int i = 0; i < 6; i++) sendByte(1, 8'hC0 + 8'(i));
    repeat (3) @(negedge clk);
    @(posedge clk); #1 dmaEn = 1'b1;
    @(negedge clk);
    check(dmaReq == 1'b1, "R9 request raised", dmaReq, 1);
    dmaPulse(0); dmaPulse(0); dmaPulse(1);
    @(negedge clk);
    check(dmaReq == 1'b0 && fifoLevel == 3, "R9 stop on tc", dmaReq, 0);
    @(posedge clk); #1 dmaEn = 1'b0;
    @(posedge clk); #1 dmaEn = 1'b1;
    @(negedge clk);
    check(dmaReq == 1'b1, "R9 re-armed", dmaReq, 1);
    dmaPulse(0); dmaPulse(0); dmaPulse(0);
    @(negedge clk);
    check(dmaReq == 1'b0 && fifoLevel == 0, "R9 stop on empty", fifoLevel, 0);
    @(posedge clk); #1 dmaEn = 1'b0;

    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && fifoLevel == 0, "R5 all bytes delivered", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule